// File: doc/BRIEF.md
# Four-Byte Operand Buffer

The block is a small byte-wide store that collects up to four bytes, such as the operand bytes of an instruction or a multi-byte data value being assembled from an 8-bit bus. Bytes arrive one per write and land at the position given by the current fill count, so the first byte becomes the least significant byte of the packed word. The whole packed word is visible at all times, so a finished operand can be used directly as an address or a program counter value.

The same storage can be drained in two ways. An ascending read walks a separate read pointer from the least significant byte upward, giving first-in first-out order. A descending read pops from the fill end, giving last-in first-out order. A peek returns the byte under the read pointer without moving it. Every access that would step outside the stored bytes is dropped and raises a one-cycle error pulse. At most one command acts per cycle, chosen by a fixed priority.

Top module: `opnd_buf`

## Requirements
- R1: After reset, count_o is 0, word_o is 0, byte_o is 0 and error_o is 0.
- R2: A write with count_o below 4 stores wr_byte_i in byte lane count_o (lane n is word_o bits 8n+7 to 8n) and increments count_o on the same clock edge.
- R3: An ascending read with the read pointer below count_o loads byte_o with the lane at the read pointer and advances the pointer by one.
- R4: A peek with the read pointer below count_o loads byte_o with the lane at the read pointer and leaves the pointer unchanged.
- R5: A descending read with count_o above 0 decrements count_o and loads byte_o with the lane at the new count; the lane contents in word_o are left unchanged.
- R6: Clear sets count_o, the read pointer, word_o and byte_o to 0.
- R7: A write with count_o equal to 4 is ignored and error_o is 1 in the following cycle only.
- R8: An ascending read or peek with the read pointer not below count_o is ignored (byte_o and pointer hold) and error_o is 1 in the following cycle only.
- R9: A descending read with count_o equal to 0 is ignored and error_o is 1 in the following cycle only.
- R10: When several commands are raised together only one acts, by priority clear, write, descending read, ascending read, peek; the others have no effect and raise no error.
- R11: word_o always shows all four lanes; byte_o changes only on a legal read, a legal peek or a clear, and error_o is 0 after any cycle with no illegal command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Empty the buffer |
| wr_en_i | input | 1 | Append wr_byte_i at the fill end |
| wr_byte_i | input | 8 | Byte to append |
| rd_asc_i | input | 1 | Read at read pointer and advance |
| peek_i | input | 1 | Read at read pointer without advance |
| rd_desc_i | input | 1 | Pop the most recently filled byte |
| byte_o | output | 8 | Last byte returned by a read or peek |
| word_o | output | 32 | All four lanes, lane 0 least significant |
| count_o | output | 3 | Number of bytes held |
| error_o | output | 1 | One-cycle pulse after an ignored out-of-range access |

## Verification
The bench fills the buffer to every level from empty to full, advances the read pointer to every legal position, and then applies all 32 combinations of the five command inputs, comparing every output against an arithmetic model. That sweep reaches the full-buffer write, the read pointer caught up with the fill count, and the pop from an empty buffer; a design with an off-by-one bound would either corrupt a fifth lane or refuse the last legal byte, and one without the priority order would act on two commands at once. A pop after ascending reads checks that the read pointer and the fill count stay independent, and the check of word_o after pops catches a design that zeroes popped lanes.

// File: rtl/opnd_buf_pkg.sv
package opnd_buf_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_CLEAR,
    CMD_WRITE,
    CMD_DESC,
    CMD_ASC,
    CMD_PEEK
  } cmd_e;
endpackage

// File: rtl/opnd_buf_ctrl.sv
module opnd_buf_ctrl
  import opnd_buf_pkg::*;
#(
  parameter int NUM_BYTES = 4,
  localparam int CNT_W = $clog2(NUM_BYTES + 1),
  localparam int IDX_W = $clog2(NUM_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 wr_en_i,
  input  logic                 rd_asc_i,
  input  logic                 peek_i,
  input  logic                 rd_desc_i,
  output logic [CNT_W-1:0]     count_o,
  output logic [NUM_BYTES-1:0] lane_we_o,
  output logic [IDX_W-1:0]     sel_o,
  output logic                 byte_ld_o,
  output logic                 clear_o,
  output logic                 error_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_BYTES);

  cmd_e             cmd;
  logic             legal;
  logic [CNT_W-1:0] cnt_q, ptr_q, sel_full;
  logic             err_q;

  // fixed priority: clear, write, pop, ascending read, peek
  always_comb begin
    if (clear_i)        cmd = CMD_CLEAR;
    else if (wr_en_i)   cmd = CMD_WRITE;
    else if (rd_desc_i) cmd = CMD_DESC;
    else if (rd_asc_i)  cmd = CMD_ASC;
    else if (peek_i)    cmd = CMD_PEEK;
    else                cmd = CMD_NONE;
  end

  always_comb begin
    unique case (cmd)
      CMD_WRITE:         legal = cnt_q < FULL;
      CMD_DESC:          legal = cnt_q != '0;
      CMD_ASC, CMD_PEEK: legal = ptr_q < cnt_q;
      default:           legal = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ptr_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= (cmd != CMD_NONE) && !legal;
      if (cmd == CMD_CLEAR) begin
        cnt_q <= '0;
        ptr_q <= '0;
      end else if (legal) begin
        if (cmd == CMD_WRITE) cnt_q <= cnt_q + CNT_W'(1);
        if (cmd == CMD_DESC)  cnt_q <= cnt_q - CNT_W'(1);
        if (cmd == CMD_ASC)   ptr_q <= ptr_q + CNT_W'(1);
      end
    end
  end

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_we
    assign lane_we_o[i] = (cmd == CMD_WRITE) && legal && (cnt_q == CNT_W'(i));
  end

  assign sel_full  = (cmd == CMD_DESC) ? cnt_q - CNT_W'(1) : ptr_q;
  assign sel_o     = sel_full[IDX_W-1:0];
  assign byte_ld_o = legal && (cmd == CMD_DESC || cmd == CMD_ASC || cmd == CMD_PEEK);
  assign clear_o   = cmd == CMD_CLEAR;
  assign count_o   = cnt_q;
  assign error_o   = err_q;

  always_comb begin
    a_r11_count_bound: assert (!rst_ni || (cnt_q <= FULL && ptr_q <= FULL));
  end

  a_r2_write_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clear_i && count_o < FULL) |=> count_o == $past(count_o) + CNT_W'(1));

  a_r5_pop_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_desc_i && !wr_en_i && !clear_i && count_o != '0) |=> count_o == $past(count_o) - CNT_W'(1));

  a_r6_clear_ptrs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0 && ptr_q == '0 && !error_o));

  a_r7_full_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clear_i && count_o == FULL) |=> (error_o && $stable(count_o)));

  a_r9_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_desc_i && !wr_en_i && !clear_i && count_o == '0) |=> (error_o && count_o == '0));

  a_r8_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !wr_en_i && !rd_desc_i && rd_asc_i && ptr_q >= count_o) |=> (error_o && $stable(ptr_q)));
endmodule

// File: rtl/opnd_buf_store.sv
module opnd_buf_store #(
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 8,
  localparam int IDX_W    = $clog2(NUM_BYTES),
  localparam int WORD_W   = NUM_BYTES * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic [NUM_BYTES-1:0] lane_we_i,
  input  logic [BYTE_W-1:0]    wr_byte_i,
  input  logic [IDX_W-1:0]     sel_i,
  input  logic                 byte_ld_i,
  output logic [BYTE_W-1:0]    byte_o,
  output logic [WORD_W-1:0]    word_o
);
  logic [BYTE_W-1:0] lane_q [NUM_BYTES];
  logic [BYTE_W-1:0] byte_q;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           lane_q[i] <= '0;
      else if (clear_i)      lane_q[i] <= '0;
      else if (lane_we_i[i]) lane_q[i] <= wr_byte_i;
    end
    assign word_o[i*BYTE_W +: BYTE_W] = lane_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        byte_q <= '0;
    else if (clear_i)   byte_q <= '0;
    else if (byte_ld_i) byte_q <= lane_q[sel_i];
  end

  assign byte_o = byte_q;

  always_comb begin
    a_r2_one_lane: assert (!rst_ni || $onehot0(lane_we_i));
  end

  a_r6_clear_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (word_o == '0 && byte_o == '0));

  a_r11_byte_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !byte_ld_i) |=> $stable(byte_o));

  a_r5_lane_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && lane_we_i == '0) |=> $stable(word_o));
endmodule

// File: rtl/opnd_buf.sv
module opnd_buf #(
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 8,
  localparam int CNT_W    = $clog2(NUM_BYTES + 1),
  localparam int IDX_W    = $clog2(NUM_BYTES),
  localparam int WORD_W   = NUM_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic              rd_asc_i,
  input  logic              peek_i,
  input  logic              rd_desc_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              error_o
);
  logic [NUM_BYTES-1:0] lane_we;
  logic [IDX_W-1:0]     sel;
  logic                 byte_ld, clr;

  opnd_buf_ctrl #(.NUM_BYTES(NUM_BYTES)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .wr_en_i   (wr_en_i),
    .rd_asc_i  (rd_asc_i),
    .peek_i    (peek_i),
    .rd_desc_i (rd_desc_i),
    .count_o   (count_o),
    .lane_we_o (lane_we),
    .sel_o     (sel),
    .byte_ld_o (byte_ld),
    .clear_o   (clr),
    .error_o   (error_o)
  );

  opnd_buf_store #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clr),
    .lane_we_i (lane_we),
    .wr_byte_i (wr_byte_i),
    .sel_i     (sel),
    .byte_ld_i (byte_ld),
    .byte_o    (byte_o),
    .word_o    (word_o)
  );
endmodule

// File: tb/opnd_buf_test.sv
`timescale 1ns/1ps
module opnd_buf_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0, wr_en_i = 1'b0, rd_asc_i = 1'b0, peek_i = 1'b0, rd_desc_i = 1'b0;
  logic [7:0]  wr_byte_i = '0;
  logic [7:0]  byte_o;
  logic [31:0] word_o;
  logic [2:0]  count_o;
  logic        error_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_lane [4];
  int         m_cnt, m_ptr;
  logic [7:0] m_byte;
  logic       m_err;

  always #2.5 clk = ~clk;

  opnd_buf uut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .wr_en_i(wr_en_i),
    .wr_byte_i(wr_byte_i), .rd_asc_i(rd_asc_i), .peek_i(peek_i),
    .rd_desc_i(rd_desc_i), .byte_o(byte_o), .word_o(word_o),
    .count_o(count_o), .error_o(error_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_word();
    return {m_lane[3], m_lane[2], m_lane[1], m_lane[0]};
  endfunction

  task automatic compare(input string tag);
    chk(tag, "count", 32'(count_o), 32'(m_cnt));
    chk(tag, "byte", 32'(byte_o), 32'(m_byte));
    chk(tag, "error", 32'(error_o), 32'(m_err));
    chk({tag, "/R11"}, "word", word_o, m_word());
  endtask

  task automatic op(input logic cl, input logic wr, input logic [7:0] b,
                    input logic asc, input logic pk, input logic ds);
    string tag;
    @(negedge clk);
    clear_i = cl; wr_en_i = wr; wr_byte_i = b; rd_asc_i = asc; peek_i = pk; rd_desc_i = ds;
    m_err = 1'b0;
    if (cl) begin
      tag = "R6";
      m_cnt = 0; m_ptr = 0; m_byte = '0;
      for (int i = 0; i < 4; i++) m_lane[i] = '0;
    end else if (wr) begin
      if (m_cnt == 4) begin tag = "R7"; m_err = 1'b1; end
      else begin tag = "R2"; m_lane[m_cnt] = b; m_cnt++; end
    end else if (ds) begin
      if (m_cnt == 0) begin tag = "R9"; m_err = 1'b1; end
      else begin tag = "R5"; m_cnt--; m_byte = m_lane[m_cnt]; end
    end else if (asc) begin
      if (m_ptr >= m_cnt) begin tag = "R8"; m_err = 1'b1; end
      else begin tag = "R3"; m_byte = m_lane[m_ptr]; m_ptr++; end
    end else if (pk) begin
      if (m_ptr >= m_cnt) begin tag = "R8"; m_err = 1'b1; end
      else begin tag = "R4"; m_byte = m_lane[m_ptr]; end
    end else tag = "R11";
    if (int'(cl) + int'(wr) + int'(asc) + int'(pk) + int'(ds) > 1) tag = {tag, "/R10"};
    @(posedge clk);
    #1;
    compare(tag);
    clear_i = 1'b0; wr_en_i = 1'b0; rd_asc_i = 1'b0; peek_i = 1'b0; rd_desc_i = 1'b0;
  endtask

  initial begin
    m_cnt = 0; m_ptr = 0; m_byte = '0; m_err = 1'b0;
    for (int i = 0; i < 4; i++) m_lane[i] = '0;
    #12 rst_ni = 1'b1;
    #1;
    compare("R1");

    // idle cycle keeps error low
    op(0, 0, 8'h00, 0, 0, 0);

    // fill levels x read positions x all command combinations
    for (int k = 0; k <= 4; k++) begin
      for (int j = 0; j <= k; j++) begin
        for (int c = 0; c < 32; c++) begin
          op(1, 0, 8'h00, 0, 0, 0);
          for (int n = 0; n < k; n++) op(0, 1, 8'((k << 5) ^ (n << 3) ^ c ^ 8'h5A), 0, 0, 0);
          for (int n = 0; n < j; n++) op(0, 0, 8'h00, 1, 0, 0);
          op(c[0], c[1], 8'hA0 | 8'(c), c[2], c[3], c[4]);
          op(0, 0, 8'h00, 0, 1, 0);        // peek after the combination
          op(0, 0, 8'h00, 0, 0, 0);        // error back to low
        end
      end
    end

    // LIFO drain to empty, then one pop too many, then refill over popped lanes
    op(1, 0, 8'h00, 0, 0, 0);
    for (int n = 0; n < 4; n++) op(0, 1, 8'h11 * 8'(n + 1), 0, 0, 0);
    op(0, 1, 8'hEE, 0, 0, 0);
    for (int n = 0; n < 5; n++) op(0, 0, 8'h00, 0, 0, 1);
    op(0, 1, 8'h77, 0, 0, 0);
    op(0, 0, 8'h00, 1, 0, 0);
    op(0, 0, 8'h00, 1, 0, 0);

    // FIFO walk with peeks between steps
    op(1, 0, 8'h00, 0, 0, 0);
    for (int n = 0; n < 4; n++) op(0, 1, 8'hC0 + 8'(n), 0, 0, 0);
    for (int n = 0; n < 5; n++) begin
      op(0, 0, 8'h00, 0, 1, 0);
      op(0, 0, 8'h00, 1, 0, 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule